// File: doc/BRIEF.md
# Hysteresis Heater Controller

This block decides, once per clock, whether a heater should run. It compares a signed measured temperature with a signed setpoint. The comparison uses a band of configurable half-width around the setpoint. A reading at or below the lower edge of the band switches the heater on. A reading at or above the upper edge switches it off. A reading strictly between the two edges leaves the heater as it was, so the heater does not chatter when the temperature sits near the setpoint.

The on/off decision is stored in a single edge-triggered flop. The comparator logic may glitch while its inputs settle, but the stored state only samples the comparator result at a rising clock edge, so those glitches cannot disturb it. The band edges are computed two bits wider than the temperature words, so a setpoint near either end of the range does not wrap around. When both conditions hold in the same cycle, switching on wins; this can only happen with a zero half-width and the reading equal to the setpoint.

Top module: `thermo_hyst_ctrl`

## Requirements
- R1: While `rst_n` is low, `heat_en` is 0; asserting `rst_n` low forces `heat_en` to 0 without waiting for a clock edge.
- R2: When `meas_temp <= set_temp - BAND` at a rising edge, `heat_en` is 1 after that edge.
- R3: When `meas_temp >= set_temp + BAND` and the R2 condition is false at a rising edge, `heat_en` is 0 after that edge.
- R4: When `set_temp - BAND < meas_temp < set_temp + BAND` at a rising edge, `heat_en` keeps the value it had before that edge.
- R5: With `BAND = 0` and `meas_temp == set_temp`, both conditions hold and `heat_en` becomes 1 (turning on has priority).
- R6: A change on the temperature inputs reaches `heat_en` only at the next rising edge, exactly one cycle later; between edges `heat_en` does not move.
- R7: Both temperature words are two's-complement. The band edges do not wrap: with `set_temp` at the largest positive value the heater can never be switched off, and with `set_temp` at the most negative value it can never be switched on.
- R8: The comparisons are signed, so readings and setpoints below zero follow R2 to R4 the same way as positive ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the state updates on the rising edge |
| rst_n | input | 1 | Active-low reset: asserts asynchronously, releases synchronously |
| set_temp | input | TEMP_W | Setpoint, signed two's-complement |
| meas_temp | input | TEMP_W | Measured temperature, signed two's-complement |
| heat_en | output | 1 | Heater enable, driven from a flop |

## Verification
The bench builds two copies of the block. Both use 16-bit words and receive the same inputs. One copy has the default half-width of 2: the downward and upward sweeps show the switching points at setpoint−2 and setpoint+2, and the hold region between them. The other copy has a half-width of 0, where a reading equal to the setpoint makes both conditions true and shows that turning on has priority. The 16-bit width lets the bench drive setpoints at +32767 and −32768, where a comparison done at the word width would wrap.

// File: rtl/thermo_pkg.sv
package thermo_pkg;

  // Per-cycle decision produced by the threshold comparator.
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_ON   = 2'd1,
    ACT_OFF  = 2'd2
  } heat_act_e;

  // Extra headroom bits that keep setpoint +/- band from wrapping.
  localparam int unsigned GUARD_BITS = 2;

endpackage

// File: rtl/thermo_band_limits.sv
module thermo_band_limits #(
  parameter int unsigned TEMP_W = 16,
  parameter int unsigned BAND   = 2,
  parameter int unsigned EXT_W  = TEMP_W + thermo_pkg::GUARD_BITS
) (
  input  logic signed [TEMP_W-1:0] set_temp,
  output logic signed [EXT_W-1:0]  lo_lim,
  output logic signed [EXT_W-1:0]  hi_lim
);

  localparam int unsigned PAD_W = EXT_W - TEMP_W;
  localparam logic signed [EXT_W-1:0] BAND_X = EXT_W'(BAND);

  logic signed [EXT_W-1:0] sp_x;

  always_comb begin
    // Sign-extend, then offset by the half-width at the wider size.
    sp_x   = {{PAD_W{set_temp[TEMP_W-1]}}, set_temp};
    lo_lim = sp_x - BAND_X;
    hi_lim = sp_x + BAND_X;
  end

endmodule

// File: rtl/thermo_thresh_cmp.sv
module thermo_thresh_cmp
  import thermo_pkg::*;
#(
  parameter int unsigned TEMP_W = 16,
  parameter int unsigned EXT_W  = TEMP_W + thermo_pkg::GUARD_BITS
) (
  input  logic signed [TEMP_W-1:0] meas_temp,
  input  logic signed [EXT_W-1:0]  lo_lim,
  input  logic signed [EXT_W-1:0]  hi_lim,
  output heat_act_e                act
);

  localparam int unsigned PAD_W = EXT_W - TEMP_W;

  logic signed [EXT_W-1:0] meas_x;
  logic                    want_on;
  logic                    want_off;

  always_comb begin
    meas_x   = {{PAD_W{meas_temp[TEMP_W-1]}}, meas_temp};
    want_on  = (meas_x <= lo_lim);
    want_off = (meas_x >= hi_lim);
    // Turning on is checked first, so it wins when both are true.
    if (want_on) begin
      act = ACT_ON;
    end else if (want_off) begin
      act = ACT_OFF;
    end else begin
      act = ACT_HOLD;
    end
  end

endmodule

// File: rtl/thermo_state_reg.sv
module thermo_state_reg
  import thermo_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  heat_act_e act,
  output logic      heat_q
);

  logic heat_d;

  // Next-state decode.
  always_comb begin
    unique case (act)
      ACT_ON:  heat_d = 1'b1;
      ACT_OFF: heat_d = 1'b0;
      default: heat_d = heat_q;
    endcase
  end

  // State register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      heat_q <= 1'b0;
    end else begin
      heat_q <= heat_d;
    end
  end

endmodule

// File: rtl/thermo_hyst_ctrl.sv
module thermo_hyst_ctrl
  import thermo_pkg::*;
#(
  parameter int unsigned TEMP_W = 16,
  parameter int unsigned BAND   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic signed [TEMP_W-1:0] set_temp,
  input  logic signed [TEMP_W-1:0] meas_temp,
  output logic                     heat_en
);

  localparam int unsigned EXT_W = TEMP_W + GUARD_BITS;

  logic signed [EXT_W-1:0] lo_lim;
  logic signed [EXT_W-1:0] hi_lim;
  heat_act_e               act;

  thermo_band_limits #(
    .TEMP_W (TEMP_W),
    .BAND   (BAND),
    .EXT_W  (EXT_W)
  ) u_limits (
    .set_temp (set_temp),
    .lo_lim   (lo_lim),
    .hi_lim   (hi_lim)
  );

  thermo_thresh_cmp #(
    .TEMP_W (TEMP_W),
    .EXT_W  (EXT_W)
  ) u_cmp (
    .meas_temp (meas_temp),
    .lo_lim    (lo_lim),
    .hi_lim    (hi_lim),
    .act       (act)
  );

  thermo_state_reg u_state (
    .clk    (clk),
    .rst_n  (rst_n),
    .act    (act),
    .heat_q (heat_en)
  );

endmodule

// File: rtl/thermo_hyst_chk.sv
module thermo_hyst_chk #(
  parameter int unsigned TEMP_W = 16,
  parameter int unsigned BAND   = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic signed [TEMP_W-1:0] set_temp,
  input logic signed [TEMP_W-1:0] meas_temp,
  input logic                     heat_en
);

  // Reference thresholds held as 32-bit integers, independent of the RTL widths.
  int sp_i, ms_i, band_i;
  logic on_c, off_c, in_band;

  always_comb begin
    sp_i    = int'(set_temp);
    ms_i    = int'(meas_temp);
    band_i  = int'(BAND);
    on_c    = (ms_i <= sp_i - band_i);
    off_c   = (ms_i >= sp_i + band_i);
    in_band = !on_c && !off_c;
  end

  // R1
  reset_off_chk: assert property (@(posedge clk) !rst_n |-> !heat_en);

  // R2
  heat_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    on_c |=> heat_en);

  // R3
  heat_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (off_c && !on_c) |=> !heat_en);

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_band |=> $stable(heat_en));

  // R5
  set_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (on_c && off_c) |=> heat_en);

endmodule

bind thermo_hyst_ctrl thermo_hyst_chk #(
  .TEMP_W (TEMP_W),
  .BAND   (BAND)
) u_hyst_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .set_temp  (set_temp),
  .meas_temp (meas_temp),
  .heat_en   (heat_en)
);

// File: tb/test_thermo_hyst_ctrl.sv
module test_thermo_hyst_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int TW         = 16;
  localparam int BAND_A     = 2;
  localparam int BAND_B     = 0;

  logic                 clk;
  logic                 rst_n;
  logic signed [TW-1:0] set_temp;
  logic signed [TW-1:0] meas_temp;
  logic                 heat_a;
  logic                 heat_b;

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    done     = 0;
  bit    exp_a, exp_b;
  string tag_a = "R1";
  string tag_b = "R1";

  thermo_hyst_ctrl #(.TEMP_W(TW), .BAND(BAND_A)) i_thermo_hyst_ctrl (
    .clk(clk), .rst_n(rst_n), .set_temp(set_temp), .meas_temp(meas_temp), .heat_en(heat_a)
  );

  thermo_hyst_ctrl #(.TEMP_W(TW), .BAND(BAND_B)) i_thermo_hyst_ctrl_zero (
    .clk(clk), .rst_n(rst_n), .set_temp(set_temp), .meas_temp(meas_temp), .heat_en(heat_b)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic act, input logic expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, expv);
    end
  endtask

  // Behavioural reference: next value of the enable and the rule that chose it.
  function automatic bit ref_next(input int s, input int m, input int b,
                                  input bit cur, output string tag);
    bit lo, hi;
    lo = (m <= s - b);
    hi = (m >= s + b);
    if (lo && hi) begin tag = "R5"; return 1'b1; end
    if (lo)       begin tag = (m < 0 || s < 0) ? "R8" : "R2"; return 1'b1; end
    if (hi)       begin tag = (m < 0 || s < 0) ? "R8" : "R3"; return 1'b0; end
    tag = (s == 32767 || s == -32768) ? "R7" : "R4";
    return cur;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_a = 1'b0; exp_b = 1'b0; tag_a = "R1"; tag_b = "R1";
    end else begin
      exp_a = ref_next(int'(set_temp), int'(meas_temp), BAND_A, exp_a, tag_a);
      exp_b = ref_next(int'(set_temp), int'(meas_temp), BAND_B, exp_b, tag_b);
    end
  end

  // Compare both copies with the model every cycle, away from the active edge.
  always @(negedge clk) begin
    if (!done) begin
      chk({tag_a, " (R6 latency, band 2)"}, heat_a, exp_a);
      chk({tag_b, " (R6 latency, band 0)"}, heat_b, exp_b);
    end
  end

  task automatic step(input int sp, input int m);
    set_temp  = TW'(sp);
    meas_temp = TW'(m);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; set_temp = 16'sd20; meas_temp = 16'sd0;
    repeat (3) @(negedge clk);
    chk("R1 held in reset", heat_a, 1'b0);
    chk("R1 held in reset", heat_b, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 on after release", heat_a, 1'b1);

    // Start off, then sweep down through the band and back up.
    step(20, 25);
    chk("R3 above band", heat_a, 1'b0);
    for (int t = 24; t >= 15; t--) begin
      step(20, t);
      if (t == 19) chk("R4 hold off inside band going down", heat_a, 1'b0);
      if (t == 18) chk("R2 switch on at setpoint-2", heat_a, 1'b1);
    end
    for (int t = 16; t <= 25; t++) begin
      step(20, t);
      if (t == 21) chk("R4 hold on inside band going up", heat_a, 1'b1);
      if (t == 22) chk("R3 switch off at setpoint+2", heat_a, 1'b0);
    end

    // One-cycle latency: no change between edges.
    set_temp = 16'sd20; meas_temp = 16'sd10;
    #1;
    chk("R6 no change before edge", heat_a, 1'b0);
    @(negedge clk);
    chk("R6 change after one edge", heat_a, 1'b1);

    // Negative temperatures.
    step(-100, -103);
    chk("R8 on below negative band", heat_a, 1'b1);
    step(-100, -99);
    chk("R8 hold inside negative band", heat_a, 1'b1);
    step(-100, -98);
    chk("R8 off at negative setpoint+2", heat_a, 1'b0);

    // Range limits: no wrap of the band edges.
    step(32767, 0);
    chk("R7 on with max setpoint", heat_a, 1'b1);
    step(32767, 32767);
    chk("R7 cannot switch off at max setpoint", heat_a, 1'b1);
    step(-32768, 0);
    chk("R7 off with min setpoint", heat_a, 1'b0);
    step(-32768, -32768);
    chk("R7 cannot switch on at min setpoint", heat_a, 1'b0);

    // Zero band: equality makes both conditions true; turning on wins.
    step(5, 6);
    chk("R3 zero band off above setpoint", heat_b, 1'b0);
    step(5, 5);
    chk("R5 set priority at equality", heat_b, 1'b1);
    chk("R4 band 2 holds at equality", heat_a, 1'b0);
    step(5, 6);
    chk("R3 zero band off again", heat_b, 1'b0);
    step(5, 5);
    chk("R5 set priority repeated", heat_b, 1'b1);

    // Asynchronous reset in the middle of a cycle.
    #(CLK_PERIOD/4);
    rst_n = 1'b0;
    #1;
    chk("R1 async clear band 0", heat_b, 1'b0);
    chk("R1 async clear band 2", heat_a, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    step(5, 5);
    step(5, 5);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule